// File: doc/BRIEF.md
# Multi-Width Serial Memory Read Capture

This block sits at the receive side of a serial memory host controller. It samples the read data lines of an eight-pin bus and packs the samples into bytes. One register bank serves three sources of capture events. The first is a tick from an internal capture clock, in its true or inverted phase. The second is a pulse from a sampling tap chosen by training. The third is a strobe that has already been delayed by about a quarter period, and the block samples on its edges. Finished bytes leave with a one-cycle valid pulse toward a clock-crossing FIFO.

The bus may be 1, 2, 4 or 8 lines wide. Each read samples at single or double data rate. All clocked logic runs in the capture clock domain, and each event source arrives as a signal already in that domain. At the start of each read, the controller pulses `read_start` with the wanted mode on the mode inputs. The block holds that mode until the next `read_start`, so the mode inputs are free to change while the read is in progress.

Top module: `ddr_rd_capture`

## Requirements
- R1: While reset is asserted and after its release, with no event yet, `byte_valid_o` is 0 and `byte_o` is 0.
- R2: Scheme, width, rate and phase select are latched in the cycle `read_start` is high. Changes on those inputs at any other time have no effect on the read in progress.
- R3: Width code 0 (x1) builds a byte from 8 samples of `dq_i[0]`. The first sample becomes bit 7.
- R4: Width code 1 (x2) builds a byte from 4 samples of `dq_i[1:0]`. The first sample fills bits 7:6, and `dq_i[1]` is the more significant bit.
- R5: Width code 2 (x4) builds a byte from 2 samples of `dq_i[3:0]`. The first sample fills bits 7:4.
- R6: Width code 3 (x8) completes a byte on every sample, and `byte_o` equals `dq_i` at that event.
- R7: In x1, x2 and x4, the pins above the active lanes have no effect on the assembled byte.
- R8: In DDR mode (`ddr_i`=1), every event is a sample. In SDR mode with scheme 0 (internal clock) or scheme 1 (tap), only the first event after `read_start`, the third, and so on are samples.
- R9: Scheme 2 (strobe) samples on both edges of `dqs_dly_i` in DDR mode and only on rising edges in SDR mode.
- R10: Scheme 0 uses `iclk_tick_i` when the latched phase select is 0 and `iclk_tick_n_i` when it is 1. The unselected tick has no effect.
- R11: `byte_valid_o` is high for exactly one cycle, the cycle after the clock edge that takes the last sample of a byte. `byte_o` holds its value until the next byte completes.
- R12: `read_start` discards any partial byte. An event in the same cycle as `read_start` is not sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| read_start | input | 1 | Begins a read; latches the mode and clears assembly |
| scheme_i | input | 2 | 0 internal clock, 1 trained tap, 2 strobe, 3 no events |
| width_i | input | 2 | 0 x1, 1 x2, 2 x4, 3 x8 |
| ddr_i | input | 1 | 1 double data rate, 0 single |
| inv_sel_i | input | 1 | Selects the inverted internal tick in scheme 0 |
| iclk_tick_i | input | 1 | Internal capture clock tick, true phase |
| iclk_tick_n_i | input | 1 | Internal capture clock tick, inverted phase |
| tap_ev_i | input | 1 | Capture pulse from the trained sampling tap |
| dqs_dly_i | input | 1 | Quarter-period delayed strobe level |
| dq_i | input | 8 | Memory read data pins |
| byte_o | output | 8 | Last assembled byte |
| byte_valid_o | output | 1 | One-cycle pulse when a byte completes |

## Verification
A corrupt sample counter shows up as a missing, extra or early `byte_valid_o` pulse, at the latest one byte's worth of events after the fault. A corrupt shift value or lane choice shows as a wrong `byte_o` on the next completed byte. An SDR phase bit that is out of step makes the block take the skipped events, so a byte completes with inverted data in it. A stale strobe edge register creates or loses a sample on the very next strobe transition.

// File: rtl/rdcap_pkg.sv
package rdcap_pkg;
   typedef enum logic [1:0] {
      SCH_ICLK = 2'd0,
      SCH_TAP  = 2'd1,
      SCH_STRB = 2'd2,
      SCH_NONE = 2'd3
   } sch_e;

   typedef enum logic [1:0] {
      W_X1 = 2'd0,
      W_X2 = 2'd1,
      W_X4 = 2'd2,
      W_X8 = 2'd3
   } wid_e;

   typedef struct packed {
      sch_e sch;
      wid_e wid;
      logic ddr;
      logic inv;
   } mode_t;
endpackage

// File: rtl/rdcap_mode.sv
module rdcap_mode
   import rdcap_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  read_start,
   input  mode_t mode_in,
   output mode_t mode_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '{sch: SCH_NONE, wid: W_X8, ddr: 1'b0, inv: 1'b0};
      end else if (read_start) begin
         mode_q <= mode_in;
      end
   end
endmodule

// File: rtl/rdcap_evt.sv
module rdcap_evt
   import rdcap_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  read_start,
   input  mode_t mode_q,
   input  logic  iclk_tick,
   input  logic  iclk_tick_n,
   input  logic  tap_ev,
   input  logic  dqs_dly,
   output logic  cap_ev
);
   logic dqs_q;
   logic raw_ev;
   logic skip_ph;

   // Strobe edge detector: previous level tracked every cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dqs_q <= 1'b0;
      else        dqs_q <= dqs_dly;
   end

   always_comb begin
      unique case (mode_q.sch)
         SCH_ICLK: raw_ev = mode_q.inv ? iclk_tick_n : iclk_tick;
         SCH_TAP:  raw_ev = tap_ev;
         SCH_STRB: raw_ev = mode_q.ddr ? (dqs_dly ^ dqs_q) : (dqs_dly & ~dqs_q);
         default:  raw_ev = 1'b0;
      endcase
   end

   // SDR on tick sources: every second event is the opposite edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          skip_ph <= 1'b0;
      else if (read_start) skip_ph <= 1'b0;
      else if (raw_ev)     skip_ph <= ~skip_ph;
   end

   always_comb begin
      if (read_start)                                     cap_ev = 1'b0;
      else if (mode_q.ddr || mode_q.sch == SCH_STRB)      cap_ev = raw_ev;
      else                                                cap_ev = raw_ev & ~skip_ph;
   end
endmodule

// File: rtl/rdcap_asm.sv
module rdcap_asm
   import rdcap_pkg::*;
#(
   parameter int DQ_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            read_start,
   input  wid_e            wid,
   input  logic            cap_ev,
   input  logic [DQ_W-1:0] dq,
   output logic [DQ_W-1:0] byte_q,
   output logic            byte_vld
);
   localparam int BYTE_W  = DQ_W;
   localparam int SPB_MAX = 8;
   localparam int CW      = $clog2(SPB_MAX);

   logic [BYTE_W-1:0] sh_q;
   logic [BYTE_W-1:0] cand [4];
   logic [BYTE_W-1:0] nxt;
   logic [CW-1:0]     cnt_q;
   logic [CW-1:0]     lim;

   for (genvar i = 0; i < 4; i++) begin : g_lane
      localparam int L = DQ_W >> (3 - i);
      if (L == BYTE_W) begin : g_full
         assign cand[i] = dq;
      end else begin : g_part
         assign cand[i] = {sh_q[BYTE_W-L-1:0], dq[L-1:0]};
      end
   end

   always_comb begin
      nxt = cand[wid];
      lim = CW'((SPB_MAX >> wid) - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q     <= '0;
         cnt_q    <= '0;
         byte_q   <= '0;
         byte_vld <= 1'b0;
      end else begin
         byte_vld <= 1'b0;
         if (read_start) begin
            sh_q  <= '0;
            cnt_q <= '0;
         end else if (cap_ev) begin
            if (cnt_q == lim) begin
               byte_q   <= nxt;
               byte_vld <= 1'b1;
               sh_q     <= '0;
               cnt_q    <= '0;
            end else begin
               sh_q  <= nxt;
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/ddr_rd_capture.sv
module ddr_rd_capture
   import rdcap_pkg::*;
#(
   parameter int DQ_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            read_start,
   input  logic [1:0]      scheme_i,
   input  logic [1:0]      width_i,
   input  logic            ddr_i,
   input  logic            inv_sel_i,
   input  logic            iclk_tick_i,
   input  logic            iclk_tick_n_i,
   input  logic            tap_ev_i,
   input  logic            dqs_dly_i,
   input  logic [DQ_W-1:0] dq_i,
   output logic [DQ_W-1:0] byte_o,
   output logic            byte_valid_o
);
   if (DQ_W < 8 || (DQ_W % 8) != 0) begin : g_bad_width
      $error("ddr_rd_capture: DQ_W must be a positive multiple of 8");
   end

   mode_t mode_in;
   mode_t mode_q;
   logic  cap_ev;

   assign mode_in = '{sch: sch_e'(scheme_i), wid: wid_e'(width_i), ddr: ddr_i, inv: inv_sel_i};

   rdcap_mode i_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .read_start (read_start),
      .mode_in    (mode_in),
      .mode_q     (mode_q)
   );

   rdcap_evt i_evt (
      .clk         (clk),
      .rst_n       (rst_n),
      .read_start  (read_start),
      .mode_q      (mode_q),
      .iclk_tick   (iclk_tick_i),
      .iclk_tick_n (iclk_tick_n_i),
      .tap_ev      (tap_ev_i),
      .dqs_dly     (dqs_dly_i),
      .cap_ev      (cap_ev)
   );

   rdcap_asm #(.DQ_W(DQ_W)) i_asm (
      .clk        (clk),
      .rst_n      (rst_n),
      .read_start (read_start),
      .wid        (mode_q.wid),
      .cap_ev     (cap_ev),
      .dq         (dq_i),
      .byte_q     (byte_o),
      .byte_vld   (byte_valid_o)
   );
endmodule

// File: rtl/rdcap_chk.sv
module rdcap_chk
   import rdcap_pkg::*;
#(
   parameter int DQ_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            read_start,
   input mode_t           mode_q,
   input logic            cap_ev,
   input logic [DQ_W-1:0] dq_i,
   input logic [DQ_W-1:0] byte_o,
   input logic            byte_valid_o
);
   a_r2_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
      !read_start |=> $stable(mode_q));

   a_r12_start_no_byte: assert property (@(posedge clk) disable iff (!rst_n)
      read_start |=> !byte_valid_o);

   a_r6_x8_each_sample: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_ev && mode_q.wid == W_X8) |=> (byte_valid_o && byte_o == $past(dq_i)));

   a_r11_valid_after_event: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid_o |-> $past(cap_ev));

   a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid_o && mode_q.wid != W_X8) |=> !byte_valid_o);

   a_r11_byte_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_valid_o |-> $stable(byte_o));
endmodule

bind ddr_rd_capture rdcap_chk #(.DQ_W(DQ_W)) i_rdcap_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .read_start   (read_start),
   .mode_q       (mode_q),
   .cap_ev       (cap_ev),
   .dq_i         (dq_i),
   .byte_o       (byte_o),
   .byte_valid_o (byte_valid_o)
);

// File: tb/test_ddr_rd_capture.sv
module test_ddr_rd_capture;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       read_start = 1'b0;
   logic [1:0] scheme_i = 2'd3;
   logic [1:0] width_i = 2'd0;
   logic       ddr_i = 1'b0;
   logic       inv_sel_i = 1'b0;
   logic       iclk_tick_i = 1'b0;
   logic       iclk_tick_n_i = 1'b0;
   logic       tap_ev_i = 1'b0;
   logic       dqs_dly_i = 1'b0;
   logic [7:0] dq_i = 8'h00;
   logic [7:0] byte_o;
   logic       byte_valid_o;

   int n_tests = 0;
   int n_fail  = 0;
   int nval    = 0;
   logic [7:0] lastb;
   int cur_sch = 0;
   int cur_inv = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ddr_rd_capture i_ddr_rd_capture (
      .clk(clk), .rst_n(rst_n), .read_start(read_start),
      .scheme_i(scheme_i), .width_i(width_i), .ddr_i(ddr_i), .inv_sel_i(inv_sel_i),
      .iclk_tick_i(iclk_tick_i), .iclk_tick_n_i(iclk_tick_n_i), .tap_ev_i(tap_ev_i),
      .dqs_dly_i(dqs_dly_i), .dq_i(dq_i), .byte_o(byte_o), .byte_valid_o(byte_valid_o)
   );

   // {scheme[21:20], width[19:18], ddr[17], inv[16], byte[15:8], noise[7:0]}
   localparam logic [21:0] VEC [9] = '{
      {2'd0, 2'd0, 1'b1, 1'b0, 8'hA5, 8'hFE},
      {2'd0, 2'd1, 1'b0, 1'b1, 8'h3C, 8'hF0},
      {2'd1, 2'd2, 1'b1, 1'b0, 8'h96, 8'hF0},
      {2'd1, 2'd3, 1'b0, 1'b0, 8'hC3, 8'h00},
      {2'd2, 2'd0, 1'b0, 1'b0, 8'h5A, 8'hFE},
      {2'd2, 2'd1, 1'b1, 1'b0, 8'hE1, 8'hFC},
      {2'd2, 2'd2, 1'b0, 1'b0, 8'h7E, 8'hF0},
      {2'd1, 2'd0, 1'b0, 1'b0, 8'h81, 8'hFE},
      {2'd0, 2'd3, 1'b1, 1'b0, 8'h42, 8'h00}
   };

   task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic pulse_pin(input int pin, input logic [7:0] d);
      @(negedge clk);
      dq_i = d;
      case (pin)
         0: iclk_tick_i = 1'b1;
         1: iclk_tick_n_i = 1'b1;
         2: tap_ev_i = 1'b1;
         default: dqs_dly_i = ~dqs_dly_i;
      endcase
      @(posedge clk); #1;
      if (byte_valid_o) begin nval++; lastb = byte_o; end
      @(negedge clk);
      iclk_tick_i = 1'b0; iclk_tick_n_i = 1'b0; tap_ev_i = 1'b0;
   endtask

   task automatic pulse(input logic [7:0] d);
      int pin;
      pin = (cur_sch == 0) ? cur_inv : (cur_sch == 1) ? 2 : 3;
      pulse_pin(pin, d);
   endtask

   task automatic start(input int sch, input int wid, input bit ddr, input bit inv, input bit ev_too);
      @(negedge clk);
      read_start = 1'b1;
      scheme_i = 2'(sch); width_i = 2'(wid); ddr_i = ddr; inv_sel_i = inv;
      if (ev_too) begin iclk_tick_i = 1'b1; tap_ev_i = 1'b1; dqs_dly_i = ~dqs_dly_i; end
      cur_sch = sch; cur_inv = int'(inv);
      nval = 0;
      @(posedge clk); #1;
      if (byte_valid_o) nval++;
      @(negedge clk);
      read_start = 1'b0; iclk_tick_i = 1'b0; tap_ev_i = 1'b0;
      // R2: scramble mode inputs for the rest of the read
      scheme_i = ~scheme_i; width_i = ~width_i; ddr_i = ~ddr_i; inv_sel_i = ~inv_sel_i;
   endtask

   task automatic send_byte(input int wid, input bit ddr, input logic [7:0] b, input logic [7:0] noise);
      int L, spb;
      logic [7:0] mask, d;
      L = 1 << wid; spb = 8 >> wid;
      mask = 8'((1 << L) - 1);
      for (int s = 0; s < spb; s++) begin
         d = 8'((b >> (8 - L * (s + 1)))) & mask;
         d = d | (noise & ~mask);
         pulse(d);
         if (!ddr) pulse(~d);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++; n_tests++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check(byte_valid_o == 1'b0, "R1 valid in reset", {7'd0, byte_valid_o}, 8'h00);
      check(byte_o == 8'h00, "R1 byte in reset", byte_o, 8'h00);
      @(negedge clk); rst_n = 1'b1;
      repeat (2) @(posedge clk); #1;
      check(byte_valid_o == 1'b0 && byte_o == 8'h00, "R1 after release", byte_o, 8'h00);

      // Table walk: R2..R9 across schemes, widths and rates
      for (int v = 0; v < 9; v++) begin
         logic [21:0] e;
         string tag;
         e = VEC[v];
         case (e[19:18])
            2'd0: tag = "R3 x1 (R7 R8 R9 R2)";
            2'd1: tag = "R4 x2 (R7 R8 R9 R2)";
            2'd2: tag = "R5 x4 (R7 R8 R9 R2)";
            default: tag = "R6 x8 (R8 R2)";
         endcase
         start(int'(e[21:20]), int'(e[19:18]), e[17], e[16], 1'b0);
         send_byte(int'(e[19:18]), e[17], e[15:8], e[7:0]);
         check(nval == 1, tag, 8'(nval), 8'd1);
         check(lastb == e[15:8], tag, lastb, e[15:8]);
      end

      // R12: partial byte discarded by a new read_start
      start(0, 0, 1'b1, 1'b0, 1'b0);
      pulse(8'h01); pulse(8'h01); pulse(8'h01);
      start(0, 0, 1'b1, 1'b0, 1'b0);
      send_byte(0, 1'b1, 8'h0F, 8'h00);
      check(nval == 1 && lastb == 8'h0F, "R12 partial dropped", lastb, 8'h0F);

      // R12: event in the read_start cycle is not sampled
      dq_i = 8'hEE;
      start(1, 3, 1'b1, 1'b0, 1'b1);
      check(nval == 0, "R12 event at start", 8'(nval), 8'd0);
      send_byte(3, 1'b1, 8'h33, 8'h00);
      check(nval == 1 && lastb == 8'h33, "R12 first byte after start", lastb, 8'h33);

      // R11: one-cycle pulse, data held afterwards
      @(posedge clk); #1;
      check(byte_valid_o == 1'b0, "R11 pulse width", {7'd0, byte_valid_o}, 8'h00);
      check(byte_o == 8'h33, "R11 byte held", byte_o, 8'h33);

      // R10: unselected internal tick ignored
      start(0, 3, 1'b1, 1'b1, 1'b0);
      pulse_pin(0, 8'h77);
      check(nval == 0 && byte_o == 8'h33, "R10 true tick ignored", byte_o, 8'h33);
      pulse_pin(1, 8'h55);
      check(nval == 1 && lastb == 8'h55, "R10 inverted tick used", lastb, 8'h55);

      // R9: strobe SDR falling edge ignored
      dqs_dly_i = 1'b0;
      repeat (2) @(posedge clk);
      start(2, 3, 1'b0, 1'b0, 1'b0);
      pulse_pin(3, 8'h11);
      check(nval == 1 && lastb == 8'h11, "R9 rising edge sampled", lastb, 8'h11);
      pulse_pin(3, 8'h22);
      check(nval == 1 && byte_o == 8'h11, "R9 falling edge ignored", byte_o, 8'h11);

      // R8: SDR tap skips second event
      start(1, 3, 1'b0, 1'b0, 1'b0);
      pulse_pin(2, 8'h9A);
      pulse_pin(2, 8'hBC);
      check(nval == 1 && byte_o == 8'h9A, "R8 SDR alternate skipped", byte_o, 8'h9A);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule